// File: doc/BRIEF.md
# Control-Flow Signature Watchdog

This block watches the instruction fetch stream of a processor and checks that each branch-free stretch of code was fetched intact. Every fetched word arrives with a two-bit tag. Words tagged as instructions are added into a running sum. A word tagged as a signature holds the value that the sum should have at that point. When one arrives, the block compares it with the sum, reports the result and clears the sum for the next stretch of code.

Signature words sit in memory next to the code, so they travel on the same fetch path. The block hides each one from the processor. In the same cycle as the signature fetch it raises a control line that tells the fetch path to substitute a no-operation for that word. The block does nothing until a start pulse arms it, and it stays armed until reset. Any error it records stays set until reset.

Top module: `cfsig_watchdog`

## Requirements
- R1: After reset, `err_flag`, `chk_done` and `force_nop` are all low, and the block is not armed.
- R2: Until the first `start` pulse, fetches have no effect. `force_nop`, `err_flag` and `chk_done` stay low, and words fetched before arming do not count toward the first signature.
- R3: Tag encoding: 2'b00 is an instruction word, 2'b01 is a signature word, and 2'b10 and 2'b11 are reserved.
- R4: The signature of an interval is the sum, modulo 2^W, of the W-bit instruction words fetched since the last check or since `start`. It wraps without any indication.
- R5: `force_nop` is high in the same cycle as a valid signature-tagged fetch while the block is armed, and is low in every other cycle.
- R6: Each armed signature fetch produces a one-cycle `chk_done` pulse in the following cycle. Back-to-back signature fetches produce back-to-back pulses.
- R7: If the signature word differs from the accumulated sum, `err_flag` rises in the cycle after the fetch. A matching signature leaves `err_flag` unchanged.
- R8: The sum returns to zero after every check, whether the check passed or failed.
- R9: An armed fetch with a reserved tag sets `err_flag` in the next cycle. That word is not added to the sum, does not raise `force_nop` and does not pulse `chk_done`.
- R10: `err_flag` is sticky. Only reset clears it; a later `start` or a passing check does not.
- R11: When `fetch_valid` is low, the tag and word inputs are ignored.
- R12: `start` clears the sum. A fetch in the same cycle as `start` is monitored and counts from a sum of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that arms monitoring and clears the sum |
| fetch_valid | input | 1 | Fetch word and tag are valid this cycle |
| fetch_tag | input | 2 | Tag of the fetched word (R3) |
| fetch_word | input | W | Fetched memory word |
| force_nop | output | 1 | Combinational: substitute a no-op for this fetch |
| err_flag | output | 1 | Sticky error: a signature mismatched or a reserved tag was seen |
| chk_done | output | 1 | One-cycle pulse after each comparison |

## Verification
The bench builds the block with the default width of 16 bits. At that width the modular sum wraps after only a few large words, so the wrap case (0xFFF0 plus 0x0020 gives 0x0010) can be reached directly. A long pseudo-random stream exercises many intervals. Start pulses that coincide with signature and reserved fetches show that clearing the sum and counting the same-cycle fetch combine in the right order. Back-to-back signature words show both the empty-interval check against zero and consecutive done pulses.

// File: rtl/cfsig_pkg.sv
package cfsig_pkg;
  typedef enum logic [1:0] {
    TAG_INSN = 2'b00,
    TAG_SIG  = 2'b01,
    TAG_RSV2 = 2'b10,
    TAG_RSV3 = 2'b11
  } fetch_tag_e;
endpackage

// File: rtl/cfsig_tag_decode.sv
module cfsig_tag_decode
  import cfsig_pkg::*;
(
  input  logic       fetch_valid,
  input  logic [1:0] fetch_tag,
  input  logic       monitoring,
  output logic       insn_evt,
  output logic       sig_evt,
  output logic       rsv_evt
);
  logic live;
  assign live = fetch_valid & monitoring;

  always_comb begin
    insn_evt = 1'b0;
    sig_evt  = 1'b0;
    rsv_evt  = 1'b0;
    if (live) begin
      unique case (fetch_tag_e'(fetch_tag))
        TAG_INSN: insn_evt = 1'b1;
        TAG_SIG:  sig_evt  = 1'b1;
        default:  rsv_evt  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cfsig_accum.sv
module cfsig_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         add_en,
  input  logic         restart,
  input  logic [W-1:0] word,
  output logic [W-1:0] acc_cur
);
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_d;

  function automatic logic [W-1:0] sig_fold(input logic [W-1:0] sum,
                                            input logic [W-1:0] w);
    return sum + w;
  endfunction

  assign acc_cur = clear ? '0 : acc_q;

  always_comb begin
    acc_d = acc_cur;
    if (restart)     acc_d = '0;
    else if (add_en) acc_d = sig_fold(acc_cur, word);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/cfsig_compare.sv
module cfsig_compare #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sig_evt,
  input  logic         rsv_evt,
  input  logic [W-1:0] ref_sig,
  input  logic [W-1:0] acc_cur,
  output logic         mismatch_evt,
  output logic         err_q,
  output logic         done_q
);
  function automatic logic sig_differs(input logic [W-1:0] a,
                                       input logic [W-1:0] b);
    return a != b;
  endfunction

  assign mismatch_evt = sig_evt & sig_differs(ref_sig, acc_cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= sig_evt;
      if (mismatch_evt || rsv_evt) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cfsig_watchdog.sv
module cfsig_watchdog #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         fetch_valid,
  input  logic [1:0]   fetch_tag,
  input  logic [W-1:0] fetch_word,
  output logic         force_nop,
  output logic         err_flag,
  output logic         chk_done
);
  logic         armed_q;
  logic         monitoring;
  logic         insn_evt;
  logic         sig_evt;
  logic         rsv_evt;
  logic         mismatch_evt;
  logic [W-1:0] acc_cur;

  always_ff @(posedge clk) begin
    if (!rst_n)     armed_q <= 1'b0;
    else if (start) armed_q <= 1'b1;
  end

  assign monitoring = armed_q | start;

  cfsig_tag_decode u_dec (
    .fetch_valid (fetch_valid),
    .fetch_tag   (fetch_tag),
    .monitoring  (monitoring),
    .insn_evt    (insn_evt),
    .sig_evt     (sig_evt),
    .rsv_evt     (rsv_evt)
  );

  cfsig_accum #(.W(W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .add_en  (insn_evt),
    .restart (sig_evt),
    .word    (fetch_word),
    .acc_cur (acc_cur)
  );

  cfsig_compare #(.W(W)) u_cmp (
    .clk          (clk),
    .rst_n        (rst_n),
    .sig_evt      (sig_evt),
    .rsv_evt      (rsv_evt),
    .ref_sig      (fetch_word),
    .acc_cur      (acc_cur),
    .mismatch_evt (mismatch_evt),
    .err_q        (err_flag),
    .done_q       (chk_done)
  );

  assign force_nop = sig_evt;
endmodule

// File: rtl/cfsig_watchdog_chk.sv
module cfsig_watchdog_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         fetch_valid,
  input logic [1:0]   fetch_tag,
  input logic [W-1:0] fetch_word,
  input logic         force_nop,
  input logic         err_flag,
  input logic         chk_done,
  input logic         armed_q,
  input logic         sig_evt,
  input logic         rsv_evt,
  input logic [W-1:0] acc_cur
);
  // R5
  nop_only_on_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_nop |-> (fetch_valid && fetch_tag == 2'b01));

  // R2
  idle_no_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !start) |-> !force_nop);

  // R6
  done_follows_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_evt |=> chk_done);

  // R7
  mismatch_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_evt && fetch_word != acc_cur) |=> err_flag);

  // R9
  reserved_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_evt |=> err_flag);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R12
  start_clears_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (acc_cur == '0));
endmodule

bind cfsig_watchdog cfsig_watchdog_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .fetch_valid (fetch_valid),
  .fetch_tag   (fetch_tag),
  .fetch_word  (fetch_word),
  .force_nop   (force_nop),
  .err_flag    (err_flag),
  .chk_done    (chk_done),
  .armed_q     (armed_q),
  .sig_evt     (sig_evt),
  .rsv_evt     (rsv_evt),
  .acc_cur     (acc_cur)
);

// File: tb/sim_cfsig_watchdog.sv
module sim_cfsig_watchdog;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         fetch_valid = 1'b0;
  logic [1:0]   fetch_tag = 2'b00;
  logic [W-1:0] fetch_word = '0;
  logic         force_nop, err_flag, chk_done;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference state
  int m_acc = 0;
  bit m_armed = 0;
  bit m_err = 0;
  bit m_done = 0;
  string last_label = "R1 reset";

  always #(CLK_P/2) clk = ~clk;

  cfsig_watchdog #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .fetch_valid(fetch_valid),
    .fetch_tag(fetch_tag), .fetch_word(fetch_word),
    .force_nop(force_nop), .err_flag(err_flag), .chk_done(chk_done)
  );

  task automatic cmp(input string lbl, input string sig, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", lbl, sig, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    cmp(last_label, "err_flag(R7/R10)", int'(err_flag), int'(m_err));
    cmp(last_label, "chk_done(R6)", int'(chk_done), int'(m_done));
  endtask

  task automatic step(input bit v, input int t, input int w, input bit s, input string lbl);
    bit exp_nop;
    bit mon;
    int base;
    @(negedge clk);
    check_regs();
    fetch_valid = v; fetch_tag = t[1:0]; fetch_word = w[W-1:0]; start = s;
    mon = m_armed || s;
    exp_nop = v && mon && (t == 1);
    #1;
    cmp(lbl, "force_nop(R5)", int'(force_nop), int'(exp_nop));
    @(posedge clk);
    base = s ? 0 : m_acc;
    m_done = 0;
    if (v && mon) begin
      if (t == 0) m_acc = (base + (w & 16'hFFFF)) % 65536;
      else if (t == 1) begin
        if ((w & 16'hFFFF) != base) m_err = 1;
        m_done = 1;
        m_acc = 0;
      end else begin
        m_err = 1;
        m_acc = base;
      end
    end else m_acc = base;
    if (s) m_armed = 1;
    last_label = lbl;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; start = 0; fetch_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_acc = 0; m_armed = 0; m_err = 0; m_done = 0;
    last_label = "R1 reset";
    cmp("R1", "err_flag", int'(err_flag), 0);
    cmp("R1", "chk_done", int'(chk_done), 0);
    cmp("R1", "force_nop", int'(force_nop), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    // R2: ignored before arming
    step(1, 0, 16'h1234, 0, "R2 pre-start insn");
    step(1, 1, 16'h0055, 0, "R2 pre-start sig");
    step(1, 2, 16'h0000, 0, "R2 pre-start rsv");
    // R12: start cycle word counts from zero
    step(1, 0, 16'h0100, 1, "R12 start+insn");
    step(1, 0, 16'h0023, 0, "R4 insn");
    step(0, 1, 16'h9999, 0, "R11 invalid sig ignored");
    step(0, 3, 16'h9999, 0, "R11 invalid rsv ignored");
    step(1, 1, 16'h0123, 0, "R3 sig match");
    // R4 wrap
    step(1, 0, 16'hFFF0, 0, "R4 wrap a");
    step(1, 0, 16'h0020, 0, "R4 wrap b");
    step(1, 1, 16'h0010, 0, "R4 wrap sig");
    // R8/R6 empty interval, back-to-back
    step(1, 1, 16'h0000, 0, "R8 empty sig");
    step(1, 0, 16'h0007, 0, "R8 insn");
    step(1, 1, 16'h0008, 0, "R7 mismatch");
    step(1, 0, 16'h0005, 0, "R8 after fail insn");
    step(1, 1, 16'h0005, 0, "R8 after fail sig");
    step(1, 0, 16'h0003, 1, "R10 start keeps err");
    step(1, 1, 16'h0003, 0, "R10 pass keeps err");
    step(0, 0, 0, 0, "R10 idle");
    do_reset();
    step(0, 0, 0, 1, "R12 start");
    step(1, 0, 16'h0011, 0, "R9 insn");
    step(1, 2, 16'h4444, 0, "R9 rsv 10");
    step(1, 1, 16'h0011, 0, "R9 rsv not summed");
    step(1, 3, 16'h0001, 0, "R9 rsv 11");
    do_reset();
    step(1, 0, 16'h0050, 0, "R2 pre-start insn");
    step(1, 1, 16'h0000, 1, "R12 start+sig");
    step(1, 0, 16'h0001, 0, "R12 insn");
    step(1, 2, 16'h0001, 1, "R12 start+rsv");
    step(1, 1, 16'h0000, 0, "R12 sum cleared");
    do_reset();
    step(0, 0, 0, 1, "R4 start random");
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) step(1, 1, m_acc, 0, "R4 random sig");
      else if (lfsr[2:0] == 3'd1) step(0, int'(lfsr[4:3]), int'(lfsr), 0, "R11 random idle");
      else step(1, 0, int'(lfsr), 0, "R4 random insn");
    end
    step(0, 0, 0, 0, "R6 drain");
    @(negedge clk);
    check_regs();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule